// File: doc/BRIEF.md
# Per-Thread Load/Store Queue Occupancy Tracker

This block does the slot bookkeeping for one thread's load queue and store queue. Both queues are circular rings with one slot kept back as a sentinel. Each entry stores only its sequence number and, for stores, three status flags. The block takes allocations, a commit bound, a squash point, store sends and store acknowledgements. It reports whether each queue is full, how many entries are still free, and whether the store at the writeback pointer may go to memory this cycle. It does not compare addresses, hold data or connect to the cache.

Loads and stores leave their queues at different times. A load is freed when a commit bound passes it. A commit only marks a store as committed and allowed to write back. The store stays in its slot until memory acknowledges its write and it reaches the head. A third store pointer runs between the head and the tail and marks the next store to send.

Top module: `lsq_track`

## Requirements
- R1: After reset both queues are empty, every slot pointer is 0, no full flag is set, `wb_ready_o` is low and `free_o` equals the smaller of the two usable capacities (slots minus one).
- R2: A queue's full flag is set when its occupancy is at least its slot count minus one. An allocation into a full queue is ignored, and so is any allocation made in a squash cycle.
- R3: `any_full_o` is the OR of the two full flags. `free_o` is the minimum of (load slots − 1 − load count) and (store slots − 1 − store count).
- R4: A commit frees every queued load whose sequence number is below `commit_seq_i`. The load count falls on the next cycle.
- R5: A commit sets the committed and can-writeback flags on every queued store whose sequence number is below `commit_seq_i`. It does not change the store count.
- R6: `wb_ready_o` is high exactly when the writeback pointer lies inside the occupied store window, the store there has can-writeback set and completed clear, and `mem_blocked_i` is low.
- R7: `wb_idx_o` is the writeback pointer. A cycle with `st_send_i` and `wb_ready_o` both high moves it forward by one slot, wrapping from the last slot to slot 0.
- R8: `st_ack_i` sets the completed flag of slot `st_ack_idx_i`. When the head store has been sent and is completed, it is freed, one store per cycle.
- R9: A squash removes every load and every uncommitted store whose sequence number is above `squash_seq_i`. Commits in the same cycle are ignored. Committed stores and the writeback pointer are not affected.
- R10: `ports_used_o` equals `ld_mem_i` plus one if a store is sent in the same cycle. It carries nothing over from earlier cycles.
- R11: Allocations fill slots in ring order, starting at slot 0 after reset. `ld_tail_o` and `st_tail_o` give the slot that the next accepted allocation will use, which is head plus count modulo the slot count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_alloc_i | input | 1 | Allocate a load entry |
| ld_seq_i | input | SEQ_W | Sequence number of the new load |
| st_alloc_i | input | 1 | Allocate a store entry |
| st_seq_i | input | SEQ_W | Sequence number of the new store |
| commit_i | input | 1 | Commit request |
| commit_seq_i | input | SEQ_W | Entries below this number retire |
| squash_i | input | 1 | Squash request |
| squash_seq_i | input | SEQ_W | Entries above this number are removed |
| mem_blocked_i | input | 1 | Memory cannot accept a store this cycle |
| st_send_i | input | 1 | Send the ready store to memory |
| st_ack_i | input | 1 | Memory acknowledges a store write |
| st_ack_idx_i | input | clog2(SQ_SLOTS) | Slot of the acknowledged store |
| ld_mem_i | input | 1 | A load uses a cache port this cycle |
| lq_full_o | output | 1 | Load queue full |
| sq_full_o | output | 1 | Store queue full |
| any_full_o | output | 1 | Either queue full |
| free_o | output | FREE_W | Minimum free-entry count |
| ld_cnt_o | output | clog2(LQ_SLOTS) | Loads held |
| st_cnt_o | output | clog2(SQ_SLOTS) | Stores held |
| ld_tail_o | output | clog2(LQ_SLOTS) | Next load slot |
| st_tail_o | output | clog2(SQ_SLOTS) | Next store slot |
| wb_ready_o | output | 1 | Store at the writeback pointer may be sent |
| wb_idx_o | output | clog2(SQ_SLOTS) | Writeback pointer |
| ports_used_o | output | 2 | Cache ports used this cycle |

## Verification
The assertions rely on four properties of the inputs. Sequence numbers rise in allocation order. An acknowledgement names only a store that has been sent and is not yet completed. Commit bounds never decrease. A squash point is never below the last commit bound minus one, so it cannot reach a committed store. The bench builds its stimulus to match. It takes sequence numbers from one counter that only counts up. It chooses acknowledgements from its own list of sent stores that are still incomplete. It draws each commit bound at or above the previous one, and draws each squash point from that bound minus one upward.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  // Position after moving n slots forward on a ring of the given size.
  function automatic int ring_step(int p, int n, int slots);
    return (p + n) % slots;
  endfunction

  // Distance from the head to a slot, walking forward on the ring.
  function automatic int ring_dist(int idx, int head, int slots);
    return (idx + slots - head) % slots;
  endfunction

  // Usable entries left once the sentinel slot is set aside.
  function automatic int free_of(int slots, int cnt);
    return slots - 1 - cnt;
  endfunction

  function automatic int min2(int a, int b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/lq_ring.sv
module lq_ring
  import lsq_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int SEQ_W = 16,
  localparam int PW = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_i,
  input  logic [SEQ_W-1:0] seq_i,
  input  logic             commit_i,
  input  logic [SEQ_W-1:0] commit_seq_i,
  input  logic             squash_i,
  input  logic [SEQ_W-1:0] squash_seq_i,
  output logic [PW-1:0]    cnt_o,
  output logic [PW-1:0]    tail_o,
  output logic             full_o
);
  logic [SEQ_W-1:0] seq_q [SLOTS];
  logic [PW-1:0]    head_q, cnt_q;
  logic [SLOTS-1:0] live;
  logic             take;
  int               retire_n, keep_n;

  always_comb begin
    retire_n = 0;
    keep_n   = 0;
    for (int i = 0; i < SLOTS; i++) begin
      live[i] = ring_dist(i, int'(head_q), SLOTS) < int'(cnt_q);
      if (live[i] && seq_q[i] <  commit_seq_i) retire_n++;
      if (live[i] && seq_q[i] <= squash_seq_i) keep_n++;
    end
  end

  assign full_o = int'(cnt_q) >= SLOTS - 1;
  assign take   = alloc_i && !full_o && !squash_i;
  assign tail_o = PW'(ring_step(int'(head_q), int'(cnt_q), SLOTS));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < SLOTS; i++) seq_q[i] <= '0;
    end else if (squash_i) begin
      cnt_q <= PW'(keep_n);
    end else begin
      if (commit_i) begin
        head_q <= PW'(ring_step(int'(head_q), retire_n, SLOTS));
        cnt_q  <= PW'(int'(cnt_q) - retire_n + int'(take));
      end else begin
        cnt_q  <= PW'(int'(cnt_q) + int'(take));
      end
      if (take) seq_q[tail_o] <= seq_i;
    end
  end

  a_r2_lq_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= SLOTS - 1) else $error("R2 load count beyond capacity");
  a_r2_lq_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_i && full_o) |=> cnt_q <= $past(cnt_q)) else $error("R2 load allocated while full");
  a_r9_lq_squash_head: assert property (@(posedge clk) disable iff (!rst_n)
    squash_i |=> (head_q == $past(head_q) && cnt_q <= $past(cnt_q))) else $error("R9 squash moved load head");
endmodule

// File: rtl/sq_ring.sv
module sq_ring
  import lsq_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int SEQ_W = 16,
  localparam int PW = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_i,
  input  logic [SEQ_W-1:0] seq_i,
  input  logic             commit_i,
  input  logic [SEQ_W-1:0] commit_seq_i,
  input  logic             squash_i,
  input  logic [SEQ_W-1:0] squash_seq_i,
  input  logic             mem_blocked_i,
  input  logic             send_i,
  input  logic             ack_i,
  input  logic [PW-1:0]    ack_idx_i,
  output logic [PW-1:0]    cnt_o,
  output logic [PW-1:0]    tail_o,
  output logic             full_o,
  output logic             wb_ready_o,
  output logic [PW-1:0]    wb_idx_o,
  output logic             wb_fire_o
);
  logic [SEQ_W-1:0] seq_q [SLOTS];
  logic [SLOTS-1:0] can_wb_q, cmt_q, done_q, live;
  logic [PW-1:0]    head_q, cnt_q, sent_q, wb_ptr_q;
  logic             take, rel;
  int               keep_n, base_n;

  always_comb begin
    keep_n = 0;
    for (int i = 0; i < SLOTS; i++) begin
      live[i] = ring_dist(i, int'(head_q), SLOTS) < int'(cnt_q);
      if (live[i] && (seq_q[i] <= squash_seq_i || cmt_q[i])) keep_n++;
    end
  end

  assign full_o     = int'(cnt_q) >= SLOTS - 1;
  assign take       = alloc_i && !full_o && !squash_i;
  assign tail_o     = PW'(ring_step(int'(head_q), int'(cnt_q), SLOTS));
  assign cnt_o      = cnt_q;
  assign wb_idx_o   = wb_ptr_q;
  assign wb_ready_o = (sent_q < cnt_q) && can_wb_q[wb_ptr_q] && !done_q[wb_ptr_q] && !mem_blocked_i;
  assign wb_fire_o  = wb_ready_o && send_i;
  assign rel        = (sent_q != '0) && done_q[head_q];
  assign base_n     = squash_i ? keep_n : int'(cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q   <= '0;
      cnt_q    <= '0;
      sent_q   <= '0;
      wb_ptr_q <= '0;
      can_wb_q <= '0;
      cmt_q    <= '0;
      done_q   <= '0;
      for (int i = 0; i < SLOTS; i++) seq_q[i] <= '0;
    end else begin
      cnt_q    <= PW'(base_n - int'(rel) + int'(take));
      sent_q   <= PW'(int'(sent_q) - int'(rel) + int'(wb_fire_o));
      head_q   <= PW'(ring_step(int'(head_q), int'(rel), SLOTS));
      wb_ptr_q <= PW'(ring_step(int'(wb_ptr_q), int'(wb_fire_o), SLOTS));
      for (int i = 0; i < SLOTS; i++) begin
        if (take && i == int'(tail_o)) begin
          seq_q[i]    <= seq_i;
          can_wb_q[i] <= 1'b0;
          cmt_q[i]    <= 1'b0;
          done_q[i]   <= 1'b0;
        end else begin
          if (commit_i && !squash_i && live[i] && seq_q[i] < commit_seq_i) begin
            cmt_q[i]    <= 1'b1;
            can_wb_q[i] <= 1'b1;
          end
          if (ack_i && i == int'(ack_idx_i)) done_q[i] <= 1'b1;
        end
      end
    end
  end

  a_r2_sq_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= SLOTS - 1) else $error("R2 store count beyond capacity");
  a_r6_send_committed: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire_o |-> (cmt_q[wb_ptr_q] && !mem_blocked_i)) else $error("R6 uncommitted store sent");
  a_r7_wb_step: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire_o |=> wb_ptr_q == PW'(ring_step(int'($past(wb_ptr_q)), 1, SLOTS))) else $error("R7 pointer step");
  a_r8_sent_inside: assert property (@(posedge clk) disable iff (!rst_n)
    sent_q <= cnt_q) else $error("R8 sent stores outside window");
  a_r9_sq_squash_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    squash_i |=> cnt_q <= $past(cnt_q)) else $error("R9 squash grew store queue");
endmodule

// File: rtl/lsq_track.sv
module lsq_track
  import lsq_pkg::*;
#(
  parameter int LQ_SLOTS = 8,
  parameter int SQ_SLOTS = 8,
  parameter int SEQ_W    = 16,
  localparam int LPW    = $clog2(LQ_SLOTS),
  localparam int SPW    = $clog2(SQ_SLOTS),
  localparam int FREE_W = (LPW > SPW) ? LPW : SPW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_alloc_i,
  input  logic [SEQ_W-1:0] ld_seq_i,
  input  logic             st_alloc_i,
  input  logic [SEQ_W-1:0] st_seq_i,
  input  logic             commit_i,
  input  logic [SEQ_W-1:0] commit_seq_i,
  input  logic             squash_i,
  input  logic [SEQ_W-1:0] squash_seq_i,
  input  logic             mem_blocked_i,
  input  logic             st_send_i,
  input  logic             st_ack_i,
  input  logic [SPW-1:0]   st_ack_idx_i,
  input  logic             ld_mem_i,
  output logic             lq_full_o,
  output logic             sq_full_o,
  output logic             any_full_o,
  output logic [FREE_W-1:0] free_o,
  output logic [LPW-1:0]   ld_cnt_o,
  output logic [SPW-1:0]   st_cnt_o,
  output logic [LPW-1:0]   ld_tail_o,
  output logic [SPW-1:0]   st_tail_o,
  output logic             wb_ready_o,
  output logic [SPW-1:0]   wb_idx_o,
  output logic [1:0]       ports_used_o
);
  logic wb_fire;

  lq_ring #(.SLOTS(LQ_SLOTS), .SEQ_W(SEQ_W)) u_lq (
    .clk(clk), .rst_n(rst_n),
    .alloc_i(ld_alloc_i), .seq_i(ld_seq_i),
    .commit_i(commit_i), .commit_seq_i(commit_seq_i),
    .squash_i(squash_i), .squash_seq_i(squash_seq_i),
    .cnt_o(ld_cnt_o), .tail_o(ld_tail_o), .full_o(lq_full_o)
  );

  sq_ring #(.SLOTS(SQ_SLOTS), .SEQ_W(SEQ_W)) u_sq (
    .clk(clk), .rst_n(rst_n),
    .alloc_i(st_alloc_i), .seq_i(st_seq_i),
    .commit_i(commit_i), .commit_seq_i(commit_seq_i),
    .squash_i(squash_i), .squash_seq_i(squash_seq_i),
    .mem_blocked_i(mem_blocked_i), .send_i(st_send_i),
    .ack_i(st_ack_i), .ack_idx_i(st_ack_idx_i),
    .cnt_o(st_cnt_o), .tail_o(st_tail_o), .full_o(sq_full_o),
    .wb_ready_o(wb_ready_o), .wb_idx_o(wb_idx_o), .wb_fire_o(wb_fire)
  );

  assign any_full_o   = lq_full_o || sq_full_o;
  assign free_o       = FREE_W'(min2(free_of(LQ_SLOTS, int'(ld_cnt_o)),
                                     free_of(SQ_SLOTS, int'(st_cnt_o))));
  assign ports_used_o = {1'b0, ld_mem_i} + {1'b0, wb_fire};

  a_r3_full_no_free: assert property (@(posedge clk) disable iff (!rst_n)
    any_full_o |-> free_o == '0) else $error("R3 free entries while full");
  a_r10_port_sources: assert property (@(posedge clk) disable iff (!rst_n)
    (ports_used_o == 2'd2) |-> (ld_mem_i && wb_ready_o && st_send_i)) else $error("R10 port count");
endmodule

// File: tb/lsq_track_bench.sv
module lsq_track_bench;
  localparam int L = 8;
  localparam int S = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_alloc_i = 0, st_alloc_i = 0, commit_i = 0, squash_i = 0;
  logic mem_blocked_i = 0, st_send_i = 0, st_ack_i = 0, ld_mem_i = 0;
  logic [15:0] ld_seq_i = 0, st_seq_i = 0, commit_seq_i = 0, squash_seq_i = 0;
  logic [2:0]  st_ack_idx_i = 0;
  logic lq_full_o, sq_full_o, any_full_o, wb_ready_o;
  logic [2:0] free_o, ld_cnt_o, st_cnt_o, ld_tail_o, st_tail_o, wb_idx_o;
  logic [1:0] ports_used_o;

  always #10 clk = ~clk;

  lsq_track #(.LQ_SLOTS(L), .SQ_SLOTS(S), .SEQ_W(16)) u_lsq_track (
    .clk(clk), .rst_n(rst_n),
    .ld_alloc_i(ld_alloc_i), .ld_seq_i(ld_seq_i),
    .st_alloc_i(st_alloc_i), .st_seq_i(st_seq_i),
    .commit_i(commit_i), .commit_seq_i(commit_seq_i),
    .squash_i(squash_i), .squash_seq_i(squash_seq_i),
    .mem_blocked_i(mem_blocked_i), .st_send_i(st_send_i),
    .st_ack_i(st_ack_i), .st_ack_idx_i(st_ack_idx_i), .ld_mem_i(ld_mem_i),
    .lq_full_o(lq_full_o), .sq_full_o(sq_full_o), .any_full_o(any_full_o),
    .free_o(free_o), .ld_cnt_o(ld_cnt_o), .st_cnt_o(st_cnt_o),
    .ld_tail_o(ld_tail_o), .st_tail_o(st_tail_o),
    .wb_ready_o(wb_ready_o), .wb_idx_o(wb_idx_o), .ports_used_o(ports_used_o)
  );

  int compared = 0;
  int mismatched = 0;
  bit done_run = 0;

  // Reference state: plain queues ordered oldest first.
  int lq[$];
  int sq_seq[$];
  bit sq_cmt[$];
  bit sq_done[$];
  int ld_head = 0, st_head = 0, sent = 0;
  int ns = 1, last_bound = 1;

  task automatic chk(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit exp_ready();
    return sent < sq_seq.size() && sq_cmt[sent] && !sq_done[sent] && !mem_blocked_i;
  endfunction

  task automatic compare_all();
    int lf, sf, fr;
    lf = L - 1 - lq.size();
    sf = S - 1 - sq_seq.size();
    fr = (lf < sf) ? lf : sf;
    chk("R2", "lq_full", int'(lq_full_o), int'(lq.size() >= L - 1));
    chk("R2", "sq_full", int'(sq_full_o), int'(sq_seq.size() >= S - 1));
    chk("R3", "any_full", int'(any_full_o), int'(lq.size() >= L - 1 || sq_seq.size() >= S - 1));
    chk("R3", "free", int'(free_o), fr);
    chk("R4 R9", "ld_cnt", int'(ld_cnt_o), lq.size());
    chk("R5 R8 R9", "st_cnt", int'(st_cnt_o), sq_seq.size());
    chk("R11", "ld_tail", int'(ld_tail_o), (ld_head + lq.size()) % L);
    chk("R11", "st_tail", int'(st_tail_o), (st_head + sq_seq.size()) % S);
    chk("R5 R6", "wb_ready", int'(wb_ready_o), int'(exp_ready()));
    chk("R7", "wb_idx", int'(wb_idx_o), (st_head + sent) % S);
    chk("R10", "ports_used", int'(ports_used_o), int'(ld_mem_i) + int'(exp_ready() && st_send_i));
  endtask

  task automatic model_step();
    bit fire, rel;
    int lsz, ssz, pos;
    fire = exp_ready() && st_send_i;
    rel  = sent > 0 && sq_done[0];
    lsz  = lq.size();
    ssz  = sq_seq.size();
    if (st_ack_i) begin
      pos = (int'(st_ack_idx_i) - st_head + S) % S;
      sq_done[pos] = 1'b1;
    end
    if (squash_i) begin
      while (lq.size() > 0 && lq[$] > int'(squash_seq_i)) void'(lq.pop_back());
      while (sq_seq.size() > 0 && sq_seq[$] > int'(squash_seq_i) && !sq_cmt[$]) begin
        void'(sq_seq.pop_back()); void'(sq_cmt.pop_back()); void'(sq_done.pop_back());
      end
    end else begin
      if (commit_i) begin
        while (lq.size() > 0 && lq[0] < int'(commit_seq_i)) begin
          void'(lq.pop_front());
          ld_head = (ld_head + 1) % L;
        end
        foreach (sq_seq[k]) if (sq_seq[k] < int'(commit_seq_i)) sq_cmt[k] = 1'b1;
      end
      if (ld_alloc_i && lsz < L - 1) lq.push_back(int'(ld_seq_i));
      if (st_alloc_i && ssz < S - 1) begin
        sq_seq.push_back(int'(st_seq_i)); sq_cmt.push_back(1'b0); sq_done.push_back(1'b0);
      end
    end
    if (rel) begin
      void'(sq_seq.pop_front()); void'(sq_cmt.pop_front()); void'(sq_done.pop_front());
      st_head = (st_head + 1) % S;
    end
    sent = sent - int'(rel) + int'(fire);
  endtask

  task automatic drive(int pa, int pc, int ps);
    int cand[$];
    ld_alloc_i    = ($urandom % 100) < pa;
    st_alloc_i    = ($urandom % 100) < pa;
    ld_seq_i      = 16'(ns);
    st_seq_i      = 16'(ns + 1);
    ns += 2;
    commit_i = 0;
    if (($urandom % 100) < pc) begin
      last_bound = last_bound + int'($urandom_range(0, ns - last_bound));
      commit_i = 1;
      commit_seq_i = 16'(last_bound);
    end
    squash_i = 0;
    if (($urandom % 100) < ps) begin
      squash_i = 1;
      squash_seq_i = 16'(last_bound - 1 + int'($urandom_range(0, ns - last_bound)));
    end
    mem_blocked_i = ($urandom % 100) < 20;
    st_send_i     = ($urandom % 100) < 70;
    ld_mem_i      = ($urandom % 100) < 50;
    st_ack_i      = 0;
    for (int k = 0; k < sent; k++) if (!sq_done[k]) cand.push_back(k);
    if (cand.size() > 0 && ($urandom % 100) < 50) begin
      st_ack_i     = 1;
      st_ack_idx_i = 3'((st_head + cand[$urandom % cand.size()]) % S);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1", "reset ld_cnt", int'(ld_cnt_o), 0);
    chk("R1", "reset st_cnt", int'(st_cnt_o), 0);
    chk("R1", "reset any_full", int'(any_full_o), 0);
    chk("R1", "reset free", int'(free_o), 7);
    chk("R1", "reset wb_ready", int'(wb_ready_o), 0);
    chk("R1", "reset ld_tail", int'(ld_tail_o), 0);
    chk("R1", "reset st_tail", int'(st_tail_o), 0);
    chk("R1", "reset wb_idx", int'(wb_idx_o), 0);
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (c < 300)      drive(80, 0, 0);
      else if (c < 800) drive(40, 30, 0);
      else              drive(50, 25, 5);
      #1;
      compare_all();
      @(posedge clk);
      model_step();
    end
    done_run = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_run) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired before the run ended");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule